// File: doc/BRIEF.md
# Request-Paced DMA Streamer with Burst Pause

This block moves a programmed number of words from local memory to an external receiver, such as a programmable-logic device with a shallow input FIFO. The receiver controls the pace through a request line. The block answers with an acknowledge level while words are moving and a one-cycle done strobe when the transfer is complete. Each transfer is set up by four configuration inputs: a start address, a length in words, a burst size in bytes and a pause-enable flag. All four are captured when a transfer is accepted.

In continuous mode the engine reads one word per cycle until the whole length has gone out. In paused mode it stops after each burst and waits for the receiver to ask again. The receiver must drop its request and then raise it again, so one request gives exactly one burst. The engine reads through a synchronous port with one cycle of latency. Each returned word is passed to the receiver with a valid flag in the cycle after the read.

Top module: `dma_burst_pause`

## Requirements
- R1: When the engine is idle, a request sampled high at a rising edge starts a transfer. The acknowledge output is high from the next cycle. The start address, length, burst size and pause flag are captured at that edge.
- R2: The acknowledge output is high exactly in the cycles that issue a read. It is low while idle, paused or signalling done.
- R3: The first read uses the start address. Each later read uses the previous address plus one word, and this sequence carries across pauses. The address wraps at the address width.
- R4: In the cycle after a read, the valid output is high and the output data equals the read data returned for that address.
- R5: With the pause flag clear, all words go out as a single unbroken run of acknowledge cycles.
- R6: With the pause flag set, the burst length in words is the burst byte count divided by 4, rounded down and treated as 1 if the result is 0. The engine pauses after every full burst that does not end the transfer.
- R7: A paused engine resumes only after the request has been sampled low and then sampled high. A request held high throughout the pause does not resume it.
- R8: When fewer words remain than the burst size, the last burst carries only the remaining words. A burst that moves the last word ends in completion, not in a pause.
- R9: The done output is a one-cycle pulse in the cycle after the last read, and acknowledge is low in that cycle.
- R10: A request present during the done cycle or the cycle after it does not start a transfer.
- R11: A request with a length of zero produces a done pulse without any read or valid beat.
- R12: While reset is held, acknowledge, done, read enable and valid are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | AW (16) | Start word address |
| cfg_len | input | LW (16) | Transfer length in words |
| cfg_burst_bytes | input | BW (12) | Burst size in bytes |
| cfg_pause_en | input | 1 | Pause after each burst when set |
| xreq | input | 1 | External request, sampled on the rising edge |
| xack | output | 1 | Transfer actively moving data |
| xdone | output | 1 | One-cycle transfer-complete pulse |
| rd_en | output | 1 | Local memory read strobe |
| rd_addr | output | AW (16) | Local memory word address |
| rd_data | input | DW (32) | Read data, valid one cycle after rd_en |
| out_valid | output | 1 | Word valid toward the external receiver |
| out_data | output | DW (32) | Word toward the external receiver |

## Verification
The assertions assume that the request line holds a defined value from reset onward and changes only between clock edges. They also assume that the memory returns data exactly one cycle after each read strobe. The bench changes request and configuration only on falling edges. Its memory model registers a fixed function of the address on each strobe, so every property about acknowledge rise, address stepping and done spacing is checked against clean, edge-aligned inputs.

// File: rtl/dma_bp_pkg.sv
package dma_bp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_XFER  = 2'd1,
        ST_PAUSE = 2'd2,
        ST_DONE  = 2'd3
    } dma_state_e;

endpackage

// File: rtl/dma_bp_ctrl.sv
module dma_bp_ctrl
    import dma_bp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       cfg_pause_en,
    input  logic       len_zero,
    input  logic       last_word,
    input  logic       burst_end,
    output dma_state_e state,
    output logic       load,
    output logic       reload,
    output logic       beat
);

    typedef struct packed {
        dma_state_e st;
        logic       armed;    // request seen low while paused
        logic       block;    // first idle cycle after done
        logic       pause_en; // captured mode
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        load   = 1'b0;
        reload = 1'b0;
        beat   = 1'b0;
        case (ctrl_q.st)
            ST_IDLE: begin
                if (ctrl_q.block) begin
                    ctrl_d.block = 1'b0;
                end else if (req) begin
                    load            = 1'b1;
                    ctrl_d.pause_en = cfg_pause_en;
                    ctrl_d.st       = len_zero ? ST_DONE : ST_XFER;
                end
            end
            ST_XFER: begin
                beat = 1'b1;
                if (last_word) begin
                    ctrl_d.st = ST_DONE;          // completion wins over pause
                end else if (ctrl_q.pause_en && burst_end) begin
                    ctrl_d.st    = ST_PAUSE;
                    ctrl_d.armed = 1'b0;
                end
            end
            ST_PAUSE: begin
                if (!req) begin
                    ctrl_d.armed = 1'b1;
                end else if (ctrl_q.armed) begin
                    reload       = 1'b1;
                    ctrl_d.armed = 1'b0;
                    ctrl_d.st    = ST_XFER;
                end
            end
            ST_DONE: begin
                ctrl_d.st    = ST_IDLE;
                ctrl_d.block = 1'b1;
            end
            default: ctrl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign state = ctrl_q.st;

endmodule

// File: rtl/dma_bp_count.sv
module dma_bp_count #(
    parameter int LW  = 16,
    parameter int BW  = 12,
    parameter int BSH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          reload,
    input  logic          beat,
    input  logic [LW-1:0] cfg_len,
    input  logic [BW-1:0] cfg_burst_bytes,
    output logic          last_word,
    output logic          burst_end
);

    typedef struct packed {
        logic [LW-1:0] rem;
        logic [BW-1:0] left;
        logic [BW-1:0] size;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic [BW-1:0] words_cfg;
    logic [BW-1:0] words_eff;

    always_comb begin
        words_cfg = cfg_burst_bytes >> BSH;
        words_eff = (words_cfg == '0) ? BW'(1) : words_cfg;
    end

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d.rem  = cfg_len;
            cnt_d.size = words_eff;
            cnt_d.left = words_eff;
        end else if (reload) begin
            cnt_d.left = cnt_q.size;
        end else if (beat) begin
            cnt_d.rem  = cnt_q.rem - LW'(1);
            cnt_d.left = cnt_q.left - BW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last_word = (cnt_q.rem == LW'(1));
    assign burst_end = (cnt_q.left == BW'(1));

endmodule

// File: rtl/dma_bp_addr.sv
module dma_bp_addr #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          beat,
    input  logic [AW-1:0] cfg_base,
    output logic [AW-1:0] addr
);

    logic [AW-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (load)      addr_d = cfg_base;
        else if (beat) addr_d = addr_q + AW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign addr = addr_q;

endmodule

// File: rtl/dma_burst_pause.sv
module dma_burst_pause
    import dma_bp_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int LW = 16,
    parameter int BW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cfg_base,
    input  logic [LW-1:0] cfg_len,
    input  logic [BW-1:0] cfg_burst_bytes,
    input  logic          cfg_pause_en,
    input  logic          xreq,
    output logic          xack,
    output logic          xdone,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] rd_data,
    output logic          out_valid,
    output logic [DW-1:0] out_data
);

    localparam int BYTES = DW / 8;
    localparam int BSH   = $clog2(BYTES);

    dma_state_e state;
    logic load, reload, beat;
    logic last_word, burst_end;
    logic valid_d, valid_q;

    dma_bp_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req          (xreq),
        .cfg_pause_en (cfg_pause_en),
        .len_zero     (cfg_len == '0),
        .last_word    (last_word),
        .burst_end    (burst_end),
        .state        (state),
        .load         (load),
        .reload       (reload),
        .beat         (beat)
    );

    dma_bp_count #(.LW(LW), .BW(BW), .BSH(BSH)) u_count (
        .clk             (clk),
        .rst_n           (rst_n),
        .load            (load),
        .reload          (reload),
        .beat            (beat),
        .cfg_len         (cfg_len),
        .cfg_burst_bytes (cfg_burst_bytes),
        .last_word       (last_word),
        .burst_end       (burst_end)
    );

    dma_bp_addr #(.AW(AW)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .beat     (beat),
        .cfg_base (cfg_base),
        .addr     (rd_addr)
    );

    always_comb valid_d = beat;

    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= valid_d;
    end

    assign rd_en     = beat;
    assign xack      = (state == ST_XFER);
    assign xdone     = (state == ST_DONE);
    assign out_valid = valid_q;
    assign out_data  = rd_data;

endmodule

// File: rtl/dma_burst_pause_chk.sv
module dma_burst_pause_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          xreq,
    input logic          xack,
    input logic          xdone,
    input logic          rd_en,
    input logic [AW-1:0] rd_addr,
    input logic          out_valid
);

    AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xack) |-> $past(xreq)); // R1

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + AW'(1))); // R3

    AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> out_valid); // R4

    AST_NO_VALID_WITHOUT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !out_valid); // R4

    AST_DONE_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        xdone |-> !xack); // R9

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        xdone |=> !xdone); // R9

    AST_POST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(xdone, 2) |-> !xack); // R10

endmodule

bind dma_burst_pause dma_burst_pause_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .xreq      (xreq),
    .xack      (xack),
    .xdone     (xdone),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .out_valid (out_valid)
);

// File: tb/dma_burst_pause_bench.sv
module dma_burst_pause_bench;

    localparam int PERIOD = 10;

    typedef struct packed {
        logic [15:0] base;
        logic [15:0] len;
        logic [11:0] bb;
        logic        pe;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{base: 16'h0100, len: 16'd8,  bb: 12'd16, pe: 1'b0},
        '{base: 16'h0200, len: 16'd8,  bb: 12'd16, pe: 1'b1},
        '{base: 16'h0300, len: 16'd10, bb: 12'd16, pe: 1'b1},
        '{base: 16'h0400, len: 16'd5,  bb: 12'd8,  pe: 1'b1},
        '{base: 16'hFFFE, len: 16'd4,  bb: 12'd4,  pe: 1'b1},
        '{base: 16'h0500, len: 16'd3,  bb: 12'd2,  pe: 1'b1},
        '{base: 16'h0600, len: 16'd6,  bb: 12'd40, pe: 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cfg_base;
    logic [15:0] cfg_len;
    logic [11:0] cfg_burst_bytes;
    logic        cfg_pause_en;
    logic        xreq;
    logic        xack, xdone, rd_en, out_valid;
    logic [15:0] rd_addr;
    logic [31:0] rd_data;
    logic [31:0] out_data;

    int n_checks = 0;
    int n_fail   = 0;

    always #(PERIOD/2) clk = ~clk;

    function automatic logic [31:0] pat(input logic [15:0] a);
        return {a ^ 16'h5A3C, ~a};
    endfunction

    always @(posedge clk) if (rd_en) rd_data <= pat(rd_addr);

    dma_burst_pause u_dma_burst_pause (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_base        (cfg_base),
        .cfg_len         (cfg_len),
        .cfg_burst_bytes (cfg_burst_bytes),
        .cfg_pause_en    (cfg_pause_en),
        .xreq            (xreq),
        .xack            (xack),
        .xdone           (xdone),
        .rd_en           (rd_en),
        .rd_addr         (rd_addr),
        .rd_data         (rd_data),
        .out_valid       (out_valid),
        .out_data        (out_data)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_xfer(input vec_t v, input int hold);
        int bw, left, run, beats, pauses, exp_run, exp_pauses;
        logic [15:0] exp_addr;
        logic seen_done, first;
        bw         = int'(v.bb) / 4;
        if (bw == 0) bw = 1;
        left       = int'(v.len);
        exp_addr   = v.base;
        run        = 0;
        beats      = 0;
        pauses     = 0;
        seen_done  = 1'b0;
        first      = 1'b1;
        exp_pauses = (v.pe && left > 0) ? ((left + bw - 1) / bw - 1) : 0;
        cfg_base        = v.base;
        cfg_len         = v.len;
        cfg_burst_bytes = v.bb;
        cfg_pause_en    = v.pe;
        xreq = 1'b1;
        @(negedge clk);
        xreq = 1'b0;
        if (v.len == 16'd0) begin
            check("R11", "zero length done", {31'd0, xdone}, 32'd1);
            check("R11", "zero length ack", {31'd0, xack}, 32'd0);
            seen_done = 1'b1;
        end else begin
            check("R1", "ack after request", {31'd0, xack}, 32'd1);
            for (int cyc = 0; cyc < 400; cyc++) begin
                if (out_valid) begin
                    check("R4", "out data", out_data, pat(exp_addr));
                    exp_addr = exp_addr + 16'd1;
                    beats++;
                end
                if (xack) begin
                    run++;
                end else begin
                    exp_run = (v.pe && bw < left) ? bw : left;
                    check("R6", "run length", run, exp_run);
                    left = left - run;
                    run  = 0;
                    if (xdone) begin
                        check("R8", "nothing left at done", left, 0);
                        seen_done = 1'b1;
                        break;
                    end
                    check("R5", "pause only in pause mode", {31'd0, v.pe}, 32'd1);
                    pauses++;
                    if (first) begin
                        for (int h = 0; h < hold; h++) begin
                            xreq = 1'b1;
                            @(negedge clk);
                            check("R7", "held request no resume", {31'd0, xack}, 32'd0);
                        end
                        first = 1'b0;
                    end
                    xreq = 1'b0;
                    @(negedge clk);
                    check("R2", "ack low in pause", {31'd0, xack}, 32'd0);
                    xreq = 1'b1;
                    @(negedge clk);
                    xreq = 1'b0;
                    check("R7", "resume after low then high", {31'd0, xack}, 32'd1);
                    continue;
                end
                @(negedge clk);
            end
            check("R3", "beat count", beats, int'(v.len));
            check("R6", "pause count", pauses, exp_pauses);
        end
        check("R9", "done seen", {31'd0, seen_done}, 32'd1);
        check("R9", "ack low at done", {31'd0, xack}, 32'd0);
        xreq = 1'b1;
        @(negedge clk);
        check("R9", "done single pulse", {31'd0, xdone}, 32'd0);
        check("R10", "request ignored after done", {31'd0, xack}, 32'd0);
        @(negedge clk);
        check("R10", "request ignored in blocked idle", {31'd0, xack}, 32'd0);
        xreq = 1'b0;
        @(negedge clk);
        check("R2", "ack low in idle", {31'd0, xack}, 32'd0);
        check("R11", "no stray valid", {31'd0, out_valid}, 32'd0);
    endtask

    initial begin
        rst_n = 1'b0;
        xreq  = 1'b0;
        cfg_base = '0;
        cfg_len = '0;
        cfg_burst_bytes = '0;
        cfg_pause_en = 1'b0;
        repeat (3) @(negedge clk);
        check("R12", "reset outputs",
              {28'd0, xack, xdone, rd_en, out_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12", "idle after reset",
              {28'd0, xack, xdone, rd_en, out_valid}, 32'd0);

        for (int i = 0; i < NV; i++) run_xfer(VEC[i], 0);

        // R7: request held high through the first pause
        run_xfer('{base: 16'h0700, len: 16'd6, bb: 12'd8, pe: 1'b1}, 3);
        // R11: zero length
        run_xfer('{base: 16'h0800, len: 16'd0, bb: 12'd8, pe: 1'b1}, 0);
        // R8: length an exact multiple of burst, last burst completes
        run_xfer('{base: 16'h0900, len: 16'd4, bb: 12'd8, pe: 1'b1}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks + 1, n_fail + 1);
        $finish;
    end

endmodule